// File: doc/BRIEF.md
# Transmit Descriptor Ring Fetcher

This block is the send-side descriptor engine of a small Ethernet MAC. Software builds a ring of 16-byte descriptors in memory, tells the engine where the ring starts, marks descriptors as belonging to hardware and then writes the poll-demand register. The engine reads the descriptor at its current pointer. If the descriptor is hardware-owned, the engine reads the buffer address and the length, fetches the buffer one 32-bit word at a time, and streams the bytes to the MAC transmitter over a ready/valid byte stream. That stream marks the start and the end of each frame. When the buffer is done, the engine writes the control word back with the owner bit cleared and moves on to the next descriptor.

A descriptor flagged end-of-ring sends the pointer back to the ring base. A frame may span several descriptors through the first-segment and last-segment flags. A descriptor with a bad length or an odd buffer address is handed back with an error flag and sends nothing. The engine keeps walking the ring without further help from software until it meets a software-owned descriptor. It then waits for the next poll-demand write.

Top module: `tx_desc_walker`

## Requirements
- R1: After reset, mem_req, tx_valid and done_irq are low and the engine is idle.
- R2: A write with cfg_sel=1 (poll demand) makes the engine read word 0 of the descriptor at the current pointer. If bit 31 (owner) of that word is 0, the engine streams no bytes, writes nothing back and stays idle until the next poll-demand write, even if memory changes in the meantime.
- R3: Descriptor layout, as byte offsets from the descriptor address. Offset 0 is the control word: bit 31 is owner (1 = hardware), bit 30 is error. Offset 4 is the length word: bits 10:0 are the length in bytes, bit 29 is first-segment, bit 28 is last-segment and bit 31 is end-of-ring. Offset 8 is the buffer byte address. Consecutive descriptors are 16 bytes apart.
- R4: A hardware-owned descriptor with a valid length sends exactly that many bytes, in rising address order, starting at the buffer address. The buffer address may be 4-aligned or only 2-aligned. The byte at address a is bits 8*(a mod 4)+7 down to 8*(a mod 4) of the 32-bit word at a rounded down to a multiple of 4.
- R5: tx_sof is high with the first byte of a descriptor only when its first-segment flag is set. tx_eof is high with its last byte only when its last-segment flag is set.
- R6: After its bytes are sent, a descriptor's control word is written back with the owner bit clear and every other bit zero except the error bit.
- R7: done_irq is a one-cycle pulse in the cycle after the write-back of a descriptor whose last-segment flag is set or which was rejected. No other write-back pulses it.
- R8: A length of 0, a length above MAX_LEN (1536) or an odd buffer address sends no bytes. The control word is written back as 0x40000000.
- R9: After a write-back, the next descriptor is read without a new poll. It is read at the ring base if the finished descriptor had end-of-ring set, and otherwise 16 bytes further on.
- R10: A write with cfg_sel=0 sets the ring base with its low 4 bits forced to 0. If the engine is idle, the write also loads the current pointer.
- R11: mem_req, once raised, stays high with mem_addr and mem_we unchanged until mem_ack. Every mem_addr is a multiple of 4.
- R12: While tx_valid is high and tx_ready is low, tx_valid, tx_data, tx_sof and tx_eof hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 = ring base, 1 = poll demand |
| cfg_wdata | input | AW | Register write data |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address, 4-aligned |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access done; read data valid this cycle |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Byte available |
| tx_data | output | 8 | Frame byte |
| tx_sof | output | 1 | First byte of a frame |
| tx_eof | output | 1 | Last byte of a frame |
| tx_ready | input | 1 | Transmitter accepts the byte |
| done_irq | output | 1 | Frame-done / reject pulse |

## Verification
A poll-demand write is registered at the next edge, and the read of word 0 is requested one cycle later. Each memory access then completes in the cycle its acknowledge is seen. A byte leaves on the edge where tx_valid and tx_ready are both high. done_irq rises one cycle after the acknowledged write-back. Because every result depends on handshakes with variable latency, the bench does not wait a fixed number of cycles. It logs each accepted byte, each acknowledged descriptor read and write-back, and each done_irq cycle at the falling edge, before the edge that acts on them. It compares these logs only after the ports have stayed quiet for 24 cycles.

// File: rtl/txw_pkg.sv
package txw_pkg;

  localparam int OWN_BIT    = 31;
  localparam int ERR_BIT    = 30;
  localparam int EOR_BIT    = 31;
  localparam int FIRST_BIT  = 29;
  localparam int LAST_BIT   = 28;
  localparam int LEN_W      = 11;
  localparam int DESC_BYTES = 16;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_CTL,
    S_RD_LEN,
    S_RD_BUF,
    S_RD_DATA,
    S_EMIT,
    S_WB
  } walk_state_e;

  typedef struct packed {
    logic             eor;
    logic             first;
    logic             last;
    logic [LEN_W-1:0] len;
  } seg_info_t;

  function automatic seg_info_t seg_decode(input logic [31:0] w);
    seg_info_t s;
    s.eor   = w[EOR_BIT];
    s.first = w[FIRST_BIT];
    s.last  = w[LAST_BIT];
    s.len   = w[LEN_W-1:0];
    return s;
  endfunction

  function automatic logic seg_bad(input seg_info_t s, input logic addr_lsb,
                                   input int unsigned max_len);
    return (s.len == '0) || (32'(s.len) > max_len) || addr_lsb;
  endfunction

  function automatic logic [31:0] wb_word(input logic err);
    logic [31:0] w;
    w = '0;
    w[ERR_BIT] = err;
    return w;
  endfunction

  function automatic logic [7:0] lane_pick(input logic [31:0] w, input logic [1:0] off);
    return 8'(w >> {off, 3'b000});
  endfunction

endpackage

// File: rtl/txw_ring_ptr.sv
module txw_ring_ptr
  import txw_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          base_we,
  input  logic          poll_we,
  input  logic [AW-1:0] wdata,
  input  logic          eng_idle,
  input  logic          poll_take,
  input  logic          advance,
  input  logic          wrap_sel,
  output logic [AW-1:0] desc_addr,
  output logic          poll_pending
);

  localparam logic [AW-1:0] SLOT_MASK = AW'(DESC_BYTES - 1);
  localparam logic [AW-1:0] SLOT_STEP = AW'(DESC_BYTES);

  logic [AW-1:0] base_q;
  logic [AW-1:0] ptr_q;
  logic          pend_q;
  logic [AW-1:0] base_in;

  assign base_in = wdata & ~SLOT_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      ptr_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (base_we) base_q <= base_in;
      if (advance)
        ptr_q <= wrap_sel ? base_q : ptr_q + SLOT_STEP;
      else if (base_we && eng_idle)
        ptr_q <= base_in;
      if (poll_we)        pend_q <= 1'b1;
      else if (poll_take) pend_q <= 1'b0;
    end
  end

  assign desc_addr    = ptr_q;
  assign poll_pending = pend_q;

endmodule

// File: rtl/txw_lane.sv
module txw_lane
  import txw_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [AW-1:0]    start_addr,
  input  logic [LEN_W-1:0] start_len,
  input  logic             word_ld,
  input  logic [31:0]      word_in,
  input  logic             step,
  output logic [7:0]       byte_out,
  output logic [AW-1:0]    fetch_addr,
  output logic             last_byte,
  output logic             word_end,
  output logic             at_head
);

  logic [AW-1:0]    addr_q;
  logic [LEN_W-1:0] left_q;
  logic [31:0]      word_q;
  logic             head_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      left_q <= '0;
      word_q <= '0;
      head_q <= 1'b0;
    end else begin
      if (start) begin
        addr_q <= start_addr;
        left_q <= start_len;
        head_q <= 1'b1;
      end else if (step) begin
        addr_q <= addr_q + AW'(1);
        left_q <= left_q - LEN_W'(1);
        head_q <= 1'b0;
      end
      if (word_ld) word_q <= word_in;
    end
  end

  assign byte_out   = lane_pick(word_q, addr_q[1:0]);
  assign fetch_addr = {addr_q[AW-1:2], 2'b00};
  assign last_byte  = (left_q == LEN_W'(1));
  assign word_end   = (addr_q[1:0] == 2'b11);
  assign at_head    = head_q;

endmodule

// File: rtl/txw_seq.sv
module txw_seq
  import txw_pkg::*;
#(
  parameter int AW      = 32,
  parameter int MAX_LEN = 1536
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             poll_pending,
  input  logic [AW-1:0]    desc_addr,
  input  logic             mem_ack,
  input  logic [31:0]      mem_rdata,
  input  logic             tx_ready,
  input  logic [7:0]       lane_byte,
  input  logic [AW-1:0]    lane_addr,
  input  logic             lane_last,
  input  logic             lane_word_end,
  input  logic             lane_head,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [31:0]      mem_wdata,
  output logic             tx_valid,
  output logic [7:0]       tx_data,
  output logic             tx_sof,
  output logic             tx_eof,
  output logic             done_irq,
  output logic             eng_idle,
  output logic             poll_take,
  output logic             advance,
  output logic             wrap_sel,
  output logic             lane_start,
  output logic [LEN_W-1:0] lane_len,
  output logic             lane_word_ld,
  output logic             lane_step,
  output logic             wb_fire
);

  walk_state_e state_q, state_d;
  seg_info_t   info_q;
  logic        err_q;
  logic        irq_q;
  logic        reject;

  assign reject = seg_bad(info_q, mem_rdata[0], MAX_LEN);

  always_comb begin
    state_d      = state_q;
    mem_req      = 1'b0;
    mem_we       = 1'b0;
    mem_addr     = '0;
    mem_wdata    = '0;
    tx_valid     = 1'b0;
    eng_idle     = 1'b0;
    poll_take    = 1'b0;
    advance      = 1'b0;
    lane_start   = 1'b0;
    lane_word_ld = 1'b0;
    lane_step    = 1'b0;
    wb_fire      = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        eng_idle = 1'b1;
        if (poll_pending) begin
          poll_take = 1'b1;
          state_d   = S_RD_CTL;
        end
      end
      S_RD_CTL: begin
        mem_req  = 1'b1;
        mem_addr = desc_addr;
        if (mem_ack) state_d = mem_rdata[OWN_BIT] ? S_RD_LEN : S_IDLE;
      end
      S_RD_LEN: begin
        mem_req  = 1'b1;
        mem_addr = desc_addr + AW'(4);
        if (mem_ack) state_d = S_RD_BUF;
      end
      S_RD_BUF: begin
        mem_req  = 1'b1;
        mem_addr = desc_addr + AW'(8);
        if (mem_ack) begin
          if (reject) state_d = S_WB;
          else begin
            lane_start = 1'b1;
            state_d    = S_RD_DATA;
          end
        end
      end
      S_RD_DATA: begin
        mem_req  = 1'b1;
        mem_addr = lane_addr;
        if (mem_ack) begin
          lane_word_ld = 1'b1;
          state_d      = S_EMIT;
        end
      end
      S_EMIT: begin
        tx_valid = 1'b1;
        if (tx_ready) begin
          lane_step = 1'b1;
          if (lane_last)          state_d = S_WB;
          else if (lane_word_end) state_d = S_RD_DATA;
        end
      end
      S_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = desc_addr;
        mem_wdata = wb_word(err_q);
        if (mem_ack) begin
          wb_fire = 1'b1;
          advance = 1'b1;
          state_d = S_RD_CTL;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      info_q  <= '0;
      err_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == S_RD_LEN && mem_ack) info_q <= seg_decode(mem_rdata);
      if (state_q == S_RD_BUF && mem_ack) err_q <= reject;
      irq_q <= wb_fire && (info_q.last || err_q);
    end
  end

  assign wrap_sel = info_q.eor;
  assign lane_len = info_q.len;
  assign tx_data  = lane_byte;
  assign tx_sof   = tx_valid && lane_head && info_q.first;
  assign tx_eof   = tx_valid && lane_last && info_q.last;
  assign done_irq = irq_q;

endmodule

// File: rtl/tx_desc_walker.sv
module tx_desc_walker
  import txw_pkg::*;
#(
  parameter int AW      = 32,
  parameter int MAX_LEN = 1536
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  output logic          tx_sof,
  output logic          tx_eof,
  input  logic          tx_ready,
  output logic          done_irq
);

  logic             eng_idle, poll_take, poll_pending, advance, wrap_sel;
  logic [AW-1:0]    desc_addr, lane_addr;
  logic             lane_start, lane_word_ld, lane_step;
  logic [LEN_W-1:0] lane_len;
  logic [7:0]       lane_byte;
  logic             lane_last, lane_word_end, lane_head;
  logic             wb_fire;

  txw_ring_ptr #(.AW(AW)) u_ptr (
    .clk          (clk),
    .rst_n        (rst_n),
    .base_we      (cfg_we && !cfg_sel),
    .poll_we      (cfg_we && cfg_sel),
    .wdata        (cfg_wdata),
    .eng_idle     (eng_idle),
    .poll_take    (poll_take),
    .advance      (advance),
    .wrap_sel     (wrap_sel),
    .desc_addr    (desc_addr),
    .poll_pending (poll_pending)
  );

  txw_lane #(.AW(AW)) u_lane (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (lane_start),
    .start_addr (mem_rdata[AW-1:0]),
    .start_len  (lane_len),
    .word_ld    (lane_word_ld),
    .word_in    (mem_rdata),
    .step       (lane_step),
    .byte_out   (lane_byte),
    .fetch_addr (lane_addr),
    .last_byte  (lane_last),
    .word_end   (lane_word_end),
    .at_head    (lane_head)
  );

  txw_seq #(.AW(AW), .MAX_LEN(MAX_LEN)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .poll_pending  (poll_pending),
    .desc_addr     (desc_addr),
    .mem_ack       (mem_ack),
    .mem_rdata     (mem_rdata),
    .tx_ready      (tx_ready),
    .lane_byte     (lane_byte),
    .lane_addr     (lane_addr),
    .lane_last     (lane_last),
    .lane_word_end (lane_word_end),
    .lane_head     (lane_head),
    .mem_req       (mem_req),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .tx_valid      (tx_valid),
    .tx_data       (tx_data),
    .tx_sof        (tx_sof),
    .tx_eof        (tx_eof),
    .done_irq      (done_irq),
    .eng_idle      (eng_idle),
    .poll_take     (poll_take),
    .advance       (advance),
    .wrap_sel      (wrap_sel),
    .lane_start    (lane_start),
    .lane_len      (lane_len),
    .lane_word_ld  (lane_word_ld),
    .lane_step     (lane_step),
    .wb_fire       (wb_fire)
  );

endmodule

// File: rtl/txw_checker.sv
module txw_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic          wb_owner,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [7:0]    tx_data,
  input logic          tx_sof,
  input logic          tx_eof,
  input logic          done_irq,
  input logic          eng_idle,
  input logic          wb_fire
);

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  p_word_align_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00);

  p_owner_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> !wb_owner);

  p_tx_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_sof) && $stable(tx_eof));

  p_irq_after_wb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> $past(wb_fire));

  p_irq_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq);

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    eng_idle |-> !mem_req && !tx_valid);

  p_stream_or_mem_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !mem_req);

endmodule

bind tx_desc_walker txw_checker #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_ack  (mem_ack),
  .mem_addr (mem_addr),
  .wb_owner (mem_wdata[31]),
  .tx_valid (tx_valid),
  .tx_ready (tx_ready),
  .tx_data  (tx_data),
  .tx_sof   (tx_sof),
  .tx_eof   (tx_eof),
  .done_irq (done_irq),
  .eng_idle (eng_idle),
  .wb_fire  (wb_fire)
);

// File: tb/tx_desc_walker_bench.sv
module tx_desc_walker_bench;

  localparam int AW        = 32;
  localparam int MEM_WORDS = 1024;
  localparam int BASE      = 32'h100;
  localparam int BASE2     = 32'h200;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic          cfg_sel = 1'b0;
  logic [AW-1:0] cfg_wdata = '0;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata;
  logic          mem_ack;
  logic [31:0]   mem_rdata;
  logic          tx_valid, tx_sof, tx_eof, done_irq;
  logic [7:0]    tx_data;
  logic          tx_ready;

  logic          tb_we = 1'b0;
  logic [9:0]    tb_idx = '0;
  logic [31:0]   tb_dat = '0;
  logic [31:0]   mem [MEM_WORDS];

  always #10 clk = ~clk;

  tx_desc_walker #(.AW(AW)) u_tx_desc_walker (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_sof(tx_sof), .tx_eof(tx_eof), .tx_ready(tx_ready), .done_irq(done_irq)
  );

  function automatic logic [7:0] bp(input int a);
    return 8'(a * 37 + (a >> 8) * 11 + 5);
  endfunction

  function automatic logic [31:0] fill_word(input int i);
    return {bp(4*i+3), bp(4*i+2), bp(4*i+1), bp(4*i)};
  endfunction

  // memory model: one access outstanding, acknowledged one cycle after request
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_WORDS; i++) mem[i] <= fill_word(i);
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
    end else if (tb_we) begin
      mem[tb_idx] <= tb_dat;
      mem_ack     <= 1'b0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0;
    end else if (mem_req) begin
      mem_ack <= 1'b1;
      if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[11:2]];
    end
  end

  // monitor: set ready first, then log what the next rising edge will act on
  logic [7:0]  blog [4096];
  logic        slog [4096];
  logic        elog [4096];
  int          nb = 0, nf = 0, nw = 0, nirq = 0, rc = 0;
  logic [31:0] flog [256];
  logic [31:0] wba  [256];
  logic [31:0] wbd  [256];
  int          hold_bad = 0, req_bad = 0, align_bad = 0;
  logic        prev_stall = 1'b0, prev_wait = 1'b0;
  logic [7:0]  prev_data = '0;
  logic [31:0] prev_addr = '0;

  always @(negedge clk) begin
    if (!rst_n) begin
      tx_ready = 1'b1;
    end else begin
      rc++;
      tx_ready = (rc % 5) != 3;
      if (prev_stall && (!tx_valid || tx_data != prev_data)) hold_bad++;
      prev_stall = tx_valid && !tx_ready;
      prev_data  = tx_data;
      if (tx_valid && tx_ready) begin
        blog[nb] = tx_data; slog[nb] = tx_sof; elog[nb] = tx_eof; nb++;
      end
      if (mem_req && mem_addr[1:0] != 2'b00) align_bad++;
      if (prev_wait && (!mem_req || mem_addr != prev_addr)) req_bad++;
      prev_wait = mem_req && !mem_ack;
      prev_addr = mem_addr;
      if (mem_req && mem_ack) begin
        if (mem_we) begin
          wba[nw] = mem_addr; wbd[nw] = mem_wdata; nw++;
        end else if (mem_addr < 32'h400 && mem_addr[3:0] == 4'h0) begin
          flog[nf] = mem_addr; nf++;
        end
      end
      if (done_irq) nirq++;
    end
  end

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic poke(input int addr, input logic [31:0] d);
    @(negedge clk);
    tb_we = 1'b1; tb_idx = 10'(addr >> 2); tb_dat = d;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic cfg(input bit sel, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic put_desc(input int base, input int slot, input bit own, input bit eor,
                          input bit fs, input bit ls, input int len, input int bufa);
    int a = base + 16 * slot;
    poke(a,     {own, 31'd0});
    poke(a + 4, {eor, 1'b0, fs, ls, 17'd0, 11'(len)});
    poke(a + 8, bufa);
  endtask

  task automatic wait_quiet();
    int q = 0;
    while (q < 24) begin
      @(negedge clk);
      if (mem_req || tx_valid) q = 0; else q++;
    end
  endtask

  task automatic check_seg(input int idx, input int bufa, input int len, input bit fs,
                           input bit ls, input string tag);
    int bad_b = 0, bad_f = 0;
    logic [7:0] act_b = '0, exp_b = '0;
    for (int i = 0; i < len; i++) begin
      if (blog[idx+i] != bp(bufa + i)) begin
        if (bad_b == 0) begin act_b = blog[idx+i]; exp_b = bp(bufa + i); end
        bad_b++;
      end
      if (slog[idx+i] != (fs && i == 0) || elog[idx+i] != (ls && i == len - 1)) bad_f++;
    end
    chk(bad_b == 0, {"R4 byte data ", tag}, act_b, exp_b);
    chk(bad_f == 0, {"R5 sof/eof markers ", tag}, bad_f, 0);
  endtask

  task automatic run_single(input int len, input int bufa, input bit err, input string tag);
    int b0 = nb, f0 = nf, w0 = nw, i0 = nirq;
    put_desc(BASE, 0, 1'b1, 1'b1, 1'b1, 1'b1, len, bufa);
    cfg(1'b1, 0);
    wait_quiet();
    if (err) begin
      chk(nb == b0, {"R8 no bytes for rejected ", tag}, nb - b0, 0);
    end else begin
      chk(nb - b0 == len, {"R4 byte count ", tag}, nb - b0, len);
      check_seg(b0, bufa, len, 1'b1, 1'b1, tag);
    end
    chk(nw == w0 + 1 && wba[w0] == BASE, {"R6 single write-back ", tag}, nw - w0, 1);
    chk(wbd[w0] == (err ? 32'h4000_0000 : 32'h0), {"R6 R8 control word ", tag},
        wbd[w0], err ? 32'h4000_0000 : 32'h0);
    chk(nirq == i0 + 1, {"R7 done pulse ", tag}, nirq - i0, 1);
    chk(nf == f0 + 2 && flog[f0] == BASE && flog[f0+1] == BASE, {"R9 end-of-ring wrap ", tag},
        (nf > f0 + 1) ? flog[f0+1] : 0, BASE);
  endtask

  task automatic run_all();
    int b0, f0, w0, i0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!mem_req && !tx_valid && !done_irq, "R1 outputs after reset",
        {mem_req, tx_valid, done_irq}, 0);
    cfg(1'b0, BASE);

    // sweep lengths and 4-/2-aligned buffers
    for (int off = 0; off <= 2; off += 2)
      for (int len = 1; len <= 9; len++)
        run_single(len, 32'h400 + off, 1'b0, $sformatf("len%0d off%0d", len, off));

    // three-segment frame, walked without extra polls (R3 slot spacing)
    b0 = nb; f0 = nf; w0 = nw; i0 = nirq;
    put_desc(BASE, 0, 1, 0, 1, 0, 5, 32'h402);
    put_desc(BASE, 1, 1, 0, 0, 0, 3, 32'h500);
    put_desc(BASE, 2, 1, 1, 0, 1, 4, 32'h602);
    cfg(1'b1, 0);
    wait_quiet();
    chk(nb - b0 == 12, "R4 multi-segment count", nb - b0, 12);
    check_seg(b0,     32'h402, 5, 1, 0, "seg0");
    check_seg(b0 + 5, 32'h500, 3, 0, 0, "seg1");
    check_seg(b0 + 8, 32'h602, 4, 0, 1, "seg2");
    chk(nf == f0 + 4 && flog[f0+1] == BASE + 16 && flog[f0+2] == BASE + 32,
        "R3 R9 sequential descriptor fetch", (nf > f0 + 2) ? flog[f0+2] : 0, BASE + 32);
    chk(nf == f0 + 4 && flog[f0+3] == BASE, "R9 wrap after ring end",
        (nf > f0 + 3) ? flog[f0+3] : 0, BASE);
    chk(nw == w0 + 3 && wba[w0+1] == BASE + 16, "R6 three write-backs", nw - w0, 3);
    chk(nirq == i0 + 1, "R7 one pulse per multi-segment frame", nirq - i0, 1);

    // rejected descriptors
    run_single(0,    32'h400, 1'b1, "zero length");
    run_single(1537, 32'h400, 1'b1, "over length");
    run_single(7,    32'h401, 1'b1, "odd buffer");
    run_single(1536, 32'h800, 1'b0, "max length");

    // software-owned: idle until the next poll
    b0 = nb; f0 = nf; w0 = nw; i0 = nirq;
    put_desc(BASE, 0, 0, 1, 1, 1, 6, 32'h402);
    cfg(1'b1, 0);
    wait_quiet();
    chk(nf == f0 + 1 && nb == b0 && nw == w0, "R2 software-owned sends nothing",
        nb - b0 + nw - w0, 0);
    poke(BASE, 32'h8000_0000);
    repeat (40) @(negedge clk);
    chk(nf == f0 + 1 && nb == b0, "R2 no fetch without poll", nf - f0, 1);
    cfg(1'b1, 0);
    wait_quiet();
    chk(nb - b0 == 6, "R2 poll resumes", nb - b0, 6);
    check_seg(b0, 32'h402, 6, 1, 1, "resumed");

    // base write with low bits set while idle
    b0 = nb; f0 = nf;
    put_desc(BASE2, 0, 1, 1, 1, 1, 4, 32'h700);
    cfg(1'b0, BASE2 + 12);
    cfg(1'b1, 0);
    wait_quiet();
    chk(nf == f0 + 2 && flog[f0] == BASE2 && flog[f0+1] == BASE2, "R10 base reload and mask",
        (nf > f0) ? flog[f0] : 0, BASE2);
    check_seg(b0, 32'h700, 4, 1, 1, "new base");

    chk(req_bad == 0 && align_bad == 0, "R11 memory handshake", req_bad + align_bad, 0);
    chk(hold_bad == 0, "R12 stream hold under backpressure", hold_bad, 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule